// File: doc/BRIEF.md
# Single-Pointer Traceback Survivor Memory

This block sits behind the add-compare-select stage of a 64-state, rate-1/2 convolutional decoder. It takes one 64-bit decision vector per trellis stage and returns the decoded information bits in their original order. The vector holds one survivor bit for each state. It uses no best-state search. Each block of `DEPTH` stages is traced back from state 0 alone.

Storage is two banks of `DEPTH` columns that trade roles. While one bank is being written, a single read pointer walks back through the other bank. The pointer takes two columns per stage, so it finishes the whole bank in the first half of the write period. It then idles for the second half. The traced bits come out newest-first, so they are turned around in a pair of last-in-first-out registers. As a result, the output runs as one unbroken stream with one bit per stage. The first bit appears 3·DEPTH/2 stages after the first vector of a frame.

A stage exists only in a cycle where `in_valid` is high. Idle cycles freeze the whole pipeline. `frame_start` drops all stored history and starts a new frame.

Top module: `onept_traceback`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied, and in the cycle after it is released, `out_valid` is low.
- R2: Each stage writes its 64-bit vector as one column. Columns fill one bank in order 0 to DEPTH-1, then writing moves to the other bank. Traceback never reads the bank being written.
- R3: When a bank has filled, its traceback starts at state 0 in column DEPTH-1. It reads two columns per stage toward column 0, takes DEPTH/2 stages, and then stays idle for the remaining DEPTH/2 stages of that bank period.
- R4: At a column where the current state is s (6 bits), the decoded bit is s[5]. The decision bit d is bit s of that column vector, and the state for the next older column is {s[4:0], d}.
- R5: Counting stages from 0 at frame start, the first decoded bit is produced by stage 3·DEPTH/2. `out_valid` is high in the cycle after that stage's clock edge and never earlier.
- R6: Decoded bits leave in original time order: column 0 of a block first, then the following block directly after it. Once output has started, every stage emits one bit.
- R7: A cycle with `in_valid` low writes nothing, advances nothing, and gives `out_valid` low in the next cycle.
- R8: `frame_start` empties both banks and discards pending output, and `out_valid` is low in the next cycle. If `in_valid` is high in the same cycle, that vector is stage 0 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Restart: discard history and begin a new frame |
| in_valid | input | 1 | A decision vector is present; marks one trellis stage |
| in_dec | input | 64 | Survivor decision bits, bit i for state i |
| out_bit | output | 1 | Decoded information bit |
| out_valid | output | 1 | `out_bit` holds a new bit this cycle |

## Verification
On every cycle, the embedded properties check three things. Traceback and writing never share a bank, and reversal never pops the register that is being filled. No output appears inside the 3·DEPTH/2 stage latency window, and none appears after an idle cycle or a frame restart. Once running, the output stream has no gaps. Only the bench's reference model can show that the decoded values are right. It rebuilds each block's traceback from the stored vectors and compares every cycle, which covers the state-0 start, the predecessor rule, the bit order across bank boundaries, gapped input and mid-block restarts.

// File: rtl/onept_pkg.sv
// Shared types for the single-pointer traceback survivor memory.
// Assumes nothing beyond being compiled before the modules that import it.
package onept_pkg;

    // How many banks hold a completed block since the frame began
    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_BOTH = 2'd2
    } fill_e;

endpackage

// File: rtl/onept_bank_mem.sv
// Two banks of DEPTH decision columns. There is one write port and two
// combinational read ports (the two columns visited in one stage).
// Assumes DEPTH is a power of two, and that reading is gated off (rd_en low)
// during the sleep half so the read mux stays quiet.
module onept_bank_mem #(
    parameter int ST_BITS = 6,
    parameter int DEPTH   = 64,
    localparam int NST    = 1 << ST_BITS,
    localparam int CW     = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_bank,
    input  logic [CW-1:0]  wr_col,
    input  logic [NST-1:0] wr_vec,
    input  logic           rd_en,
    input  logic           rd_bank,
    input  logic [CW-1:0]  rd_col_a,
    input  logic [CW-1:0]  rd_col_b,
    output logic [NST-1:0] rd_vec_a,
    output logic [NST-1:0] rd_vec_b
);

    logic [NST-1:0] bank_a [2];
    logic [NST-1:0] bank_b [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [NST-1:0] col_q [DEPTH];

        // Store one column per stage into the selected bank
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(g))) begin
                col_q[wr_col] <= wr_vec;
            end
        end

        assign bank_a[g] = col_q[rd_col_a];
        assign bank_b[g] = col_q[rd_col_b];
    end

    // Read mux, held at zero while the pointer sleeps
    always_comb begin
        rd_vec_a = rd_en ? bank_a[rd_bank] : '0;
        rd_vec_b = rd_en ? bank_b[rd_bank] : '0;
    end

    // R2: traceback and writing never touch the same bank in one stage
    p_bank_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_bank != wr_bank));

endmodule

// File: rtl/onept_trace.sv
// Two traceback steps per stage. From the current state it forms the decoded
// bit (state MSB) and the predecessor {state[low bits], decision}, twice in
// series. Assumes col_a_vec is the newer column and col_b_vec the next older one.
module onept_trace #(
    parameter int ST_BITS = 6,
    localparam int NST    = 1 << ST_BITS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  logic           first_step,
    input  logic [NST-1:0] col_a_vec,
    input  logic [NST-1:0] col_b_vec,
    output logic           bit_a,
    output logic           bit_b
);

    logic [ST_BITS-1:0] st_q;
    logic [ST_BITS-1:0] s_in;
    logic [ST_BITS-1:0] s_mid;
    logic [ST_BITS-1:0] s_out;

    // Walk two columns back from the current state
    always_comb begin
        s_in  = first_step ? '0 : st_q;
        bit_a = s_in[ST_BITS-1];
        s_mid = {s_in[ST_BITS-2:0], col_a_vec[s_in]};
        bit_b = s_mid[ST_BITS-1];
        s_out = {s_mid[ST_BITS-2:0], col_b_vec[s_mid]};
    end

    // Hold the state reached for the next stage's pair of reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (step_en) begin
            st_q <= s_out;
        end
    end

    // R3: every block's walk opens from state 0, so its first bit is 0
    p_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && first_step) |-> (bit_a == 1'b0));

endmodule

// File: rtl/onept_lifo_pair.sv
// Two DEPTH-bit last-in-first-out registers that alternate. One fills with
// traced bits (two per push, older column second) while the other drains one
// bit per pop. Assumes DEPTH >= 4 and that push and pop pick different registers.
module onept_lifo_pair #(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_en,
    input  logic push_sel,
    input  logic push_a,
    input  logic push_b,
    input  logic pop_en,
    input  logic pop_sel,
    output logic pop_bit
);

    logic [DEPTH-1:0] lq [2];

    for (genvar g = 0; g < 2; g++) begin : g_lifo
        // Shift in traced bits, or shift out the most recent one
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lq[g] <= '0;
            end else if (push_en && (push_sel == 1'(g))) begin
                lq[g] <= {lq[g][DEPTH-3:0], push_a, push_b};
            end else if (pop_en && (pop_sel == 1'(g))) begin
                lq[g] <= {1'b0, lq[g][DEPTH-1:1]};
            end
        end
    end

    assign pop_bit = lq[pop_sel][0];

    // R6: the register being drained is never the one being filled
    p_no_pop_from_filling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |-> (push_sel != pop_sel));

endmodule

// File: rtl/onept_traceback.sv
// Top of the single-pointer traceback survivor memory. It sequences bank
// writes, the double-speed read pointer with its sleep half, and the output
// reversal. Assumes DEPTH is a power of two >= 4, one stage per in_valid cycle,
// and that the encoder path may be traced from state 0 at each bank end.
module onept_traceback #(
    parameter int ST_BITS = 6,
    parameter int DEPTH   = 64,
    localparam int NST    = 1 << ST_BITS,
    localparam int CW     = $clog2(DEPTH),
    localparam int HALF   = DEPTH / 2,
    localparam int LAT    = 3 * DEPTH / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           in_valid,
    input  logic [NST-1:0] in_dec,
    output logic           out_bit,
    output logic           out_valid
);
    import onept_pkg::*;

    localparam logic [CW-1:0] LAST_COL = CW'(DEPTH - 1);

    logic [CW-1:0]  stg_q, stg_c;
    logic           wbank_q, wbank_c;
    fill_e          fill_q, fill_c;
    logic           first_half, last_col;
    logic           rd_en, pop_en, pop_sel, pop_bit;
    logic [CW-1:0]  col_a, col_b;
    logic [NST-1:0] vec_a, vec_b;
    logic           bit_a, bit_b;

    // Control view for this cycle, with a frame restart applied first
    always_comb begin
        stg_c      = frame_start ? '0 : stg_q;
        wbank_c    = frame_start ? 1'b0 : wbank_q;
        fill_c     = frame_start ? FILL_NONE : fill_q;
        first_half = (stg_c < CW'(HALF));
        last_col   = (stg_c == LAST_COL);
        rd_en      = in_valid && (fill_c != FILL_NONE) && first_half;
        col_a      = LAST_COL - {stg_c[CW-2:0], 1'b0};
        col_b      = col_a - 1'b1;
        pop_en     = in_valid && (first_half ? (fill_c == FILL_BOTH)
                                             : (fill_c != FILL_NONE));
        pop_sel    = first_half ? wbank_c : ~wbank_c;
    end

    // Advance the write column and swap banks when one fills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q   <= '0;
            wbank_q <= 1'b0;
            fill_q  <= FILL_NONE;
        end else if (in_valid && last_col) begin
            stg_q   <= '0;
            wbank_q <= ~wbank_c;
            fill_q  <= (fill_c == FILL_NONE) ? FILL_ONE : FILL_BOTH;
        end else if (in_valid) begin
            stg_q   <= stg_c + 1'b1;
            wbank_q <= wbank_c;
            fill_q  <= fill_c;
        end else begin
            stg_q   <= stg_c;
            wbank_q <= wbank_c;
            fill_q  <= fill_c;
        end
    end

    onept_bank_mem #(.ST_BITS(ST_BITS), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_valid),
        .wr_bank  (wbank_c),
        .wr_col   (stg_c),
        .wr_vec   (in_dec),
        .rd_en    (rd_en),
        .rd_bank  (~wbank_c),
        .rd_col_a (col_a),
        .rd_col_b (col_b),
        .rd_vec_a (vec_a),
        .rd_vec_b (vec_b)
    );

    onept_trace #(.ST_BITS(ST_BITS)) u_trace (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (rd_en),
        .first_step (stg_c == '0),
        .col_a_vec  (vec_a),
        .col_b_vec  (vec_b),
        .bit_a      (bit_a),
        .bit_b      (bit_b)
    );

    onept_lifo_pair #(.DEPTH(DEPTH)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (rd_en),
        .push_sel (~wbank_c),
        .push_a   (bit_a),
        .push_b   (bit_b),
        .pop_en   (pop_en),
        .pop_sel  (pop_sel),
        .pop_bit  (pop_bit)
    );

    // Register the outgoing bit and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= pop_en;
            out_bit   <= pop_en ? pop_bit : out_bit;
        end
    end

    // Checker-only: stages seen since frame start, saturating past LAT
    logic [CW:0] seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (in_valid) begin
            seen_q <= (frame_start ? '0 : (seen_q > (CW+1)'(LAT) ? seen_q : seen_q + 1'b1))
                      + ((frame_start) ? (CW+1)'(1) : '0);
        end else if (frame_start) begin
            seen_q <= '0;
        end
    end

    // R5: no bit before stage index LAT has been taken
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen_q > (CW+1)'(LAT)));

    // R6: once streaming, every further stage yields a bit
    p_stream_continuous_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_valid && !frame_start) |=> out_valid);

    // R7: an idle cycle produces no output
    p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: a restart leaves nothing to emit
    p_frame_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !out_valid);

endmodule

// File: tb/onept_traceback_test.sv
// Bench: a behavioural reference keeps the frame's vectors and a queue of
// expected bits, and is compared with the outputs on every clock.
module onept_traceback_test;

    localparam int D   = 64;
    localparam int LAT = 3 * D / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_dec = '0;
    logic        out_bit;
    logic        out_valid;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    logic [63:0] ref_vec [$];
    bit          exp_q [$];
    bit          exp_v = 1'b0;
    bit          exp_b = 1'b0;
    int          n_stage = 0;

    always #2.5 clk = ~clk;

    onept_traceback #(.ST_BITS(6), .DEPTH(D)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .in_dec      (in_dec),
        .out_bit     (out_bit),
        .out_valid   (out_valid)
    );

    // Decode the block that ends at stage n_stage (R3, R4): start in state 0
    task automatic trace_block();
        int base = n_stage - D + 1;
        int s = 0;
        bit blk [D];
        for (int c = D - 1; c >= 0; c--) begin
            blk[c] = s[5];
            s = ((s << 1) & 63) | int'(ref_vec[base + c][s]);
        end
        for (int c = 0; c < D; c++) exp_q.push_back(blk[c]);
    endtask

    // One clock: check the previous edge's result, then drive and predict
    task automatic step(input bit rst, input bit fs, input bit v, input logic [63:0] vec);
        @(negedge clk);
        n_cmp++;
        if (out_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s: out_valid=%b expected %b", cur_req, out_valid, exp_v);
        end else if (exp_v && (out_bit !== exp_b)) begin
            n_bad++;
            $display("FAIL R4 R6: out_bit=%b expected %b", out_bit, exp_b);
        end
        rst_n = ~rst; frame_start = fs; in_valid = v; in_dec = vec;
        exp_v = 1'b0;
        if (rst || fs) begin
            ref_vec.delete(); exp_q.delete(); n_stage = 0;
        end
        if (!rst && v) begin
            ref_vec.push_back(vec);
            if (n_stage >= LAT) begin
                exp_v = 1'b1;
                exp_b = exp_q.pop_front();
            end
            if ((n_stage % D) == D - 1) trace_block();
            n_stage++;
        end
    endtask

    task automatic run(input int cnt, input int kind, input int gap_pct);
        for (int i = 0; i < cnt; i++) begin
            logic [63:0] vec;
            case (kind)
                0: vec = {$urandom, $urandom};
                1: vec = '1;
                default: vec = '0;
            endcase
            if (gap_pct != 0 && ($urandom % 100) < gap_pct) step(1'b0, 1'b0, 1'b0, vec);
            step(1'b0, 1'b0, 1'b1, vec);
        end
    endtask

    initial begin
        // R1: output quiet under reset and just after release
        cur_req = "R1";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 1'b0, '0);
        // R2 R3 R4 R5 R6: continuous random vectors across several banks
        cur_req = "R5";
        step(1'b0, 1'b1, 1'b0, '0);
        run(4 * D, 0, 0);
        // R7: idle cycles scattered between stages
        cur_req = "R7";
        run(3 * D, 0, 40);
        // R8: restart together with a vector, mid-block
        cur_req = "R8";
        step(1'b0, 1'b1, 1'b1, {$urandom, $urandom});
        run(D + 10, 0, 0);
        step(1'b0, 1'b1, 1'b1, {$urandom, $urandom});
        run(3 * D, 0, 0);
        // R4: all-ones decisions give an all-ones predecessor chain
        cur_req = "R8";
        step(1'b0, 1'b1, 1'b0, '0);
        cur_req = "R4";
        run(3 * D, 1, 0);
        // R4 R5: all-zero decisions under a fresh frame
        step(1'b0, 1'b1, 1'b0, '0);
        run(3 * D, 2, 10);
        step(1'b0, 1'b0, 1'b0, '0);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: cycles=200000 expected fewer");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule